// File: doc/BRIEF.md
# Multiplier-Free Interpolating Root-Raised-Cosine Shaper

This block shapes two 3-bit baseband streams, an in-phase (I) and a quadrature (Q) stream, with a 32-tap symmetric root-raised-cosine response. It raises the rate by four by treating each input as followed by three zero samples. Because of the zero stuffing, every output depends on only eight stored nonzero samples per channel. The four output phases that follow one input group need only two distinct coefficient sets, since the filter is symmetric. The last two phases reuse the first two sets with the sample order reversed.

No multiplier is used. Each response is formed bit-serially by distributed arithmetic. The eight sample bits of one weight address two 4-input lookup tables of precomputed coefficient sums. The two table outputs are added in parallel, and the result goes into a scaling accumulator that shifts right once per bit. At the sign bit the table sum is subtracted instead of added, using XOR inversion plus a carry-in of one.

One datapath serves both channels. The downstream carrier mixer at a quarter of the output rate only needs I at even phases and Q at odd phases, so the block produces, per input group, I phase 0, Q phase 1, I phase 2 and Q phase 3. That is 3 clock cycles each, 12 per input. At a 60 MHz clock this matches a 200 ns input period with a 50 ns output spacing.

Top module: `rrc_da_interp`

## Requirements
- R1: After reset, `outValid` is low and `outData` is zero until an input has been accepted.
- R2: For an input accepted at clock edge E0, the four responses appear with `outValid` high just after edges E0+3, E0+6, E0+9 and E0+12.
- R3: The channel tag `outQ` (0 = I, 1 = Q) of the four responses of one input is 0, 1, 0, 1.
- R4: Response phase p (0..3) of a channel equals the sum over k = 0..7 of c[4k+p]·x[k]. Here x[0] is that channel's newest sample, x[k] the sample k inputs earlier (zero if none since reset), c[n] for n < 16 is the n-th coefficient parameter and c[n] = c[31−n] for n ≥ 16.
- R5: An I response depends only on I samples and a Q response only on Q samples.
- R6: Samples are two's complement; the sign bit carries negative weight, and the full-scale value −4 is handled exactly.
- R7: `outData` is the 10 most significant bits of the 18-bit exact result (arithmetic shift right by 8); coefficients are such that the exact result always fits in 18 bits.
- R8: Inputs may be accepted no more often than once every 12 cycles; a new input may coincide with the last bit cycle of the previous group.
- R9: `outValid` is a single-cycle pulse, exactly four per accepted input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (60 MHz nominal) |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Accepts `inI` and `inQ` on this edge |
| inI | input | 3 | In-phase sample, two's complement |
| inQ | input | 3 | Quadrature sample, two's complement |
| outValid | output | 1 | One-cycle pulse per computed response |
| outQ | output | 1 | Channel tag of the response: 0 = I, 1 = Q |
| outData | output | 10 | Top bits of the filtered response, two's complement |

## Verification
The assertions assume that `inValid` never rises while a group is still being computed, except on its final bit cycle. They also assume that the coefficient parameters keep every exact response inside 18 bits. The stimulus presents inputs exactly 12 cycles apart, which is the tightest legal spacing. The coefficient set it uses has a worst-case phase sum well below the overflow limit, even with all eight samples at −4. Impulses, full-scale negative values, alternating extremes and a pseudo-random sequence are compared against a direct multiply-accumulate model of the zero-stuffed filter.

// File: rtl/rrc_da_pkg.sv
package rrc_da_pkg;
  parameter int SAMPLE_W = 3;
  parameter int TAPS_PER_PHASE = 8;
  parameter int INTERP = 4;
  localparam int BIT_IW = $clog2(SAMPLE_W);
  localparam int SLOT_W = $clog2(INTERP);

  typedef struct packed {
    logic shiftIn;
    logic active;
    logic [SLOT_W-1:0] slot;
    logic [BIT_IW-1:0] bitIdx;
    logic lastBit;
  } ctrlStrobes_t;
endpackage

// File: rtl/rrc_da_ctrl.sv
module rrc_da_ctrl
  import rrc_da_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  output ctrlStrobes_t strobes
);
  logic active;
  logic [SLOT_W-1:0] slot;
  logic [BIT_IW-1:0] bitIdx;
  logic lastBit;
  logic groupEnd;

  assign lastBit = active && (bitIdx == BIT_IW'(SAMPLE_W-1));
  assign groupEnd = lastBit && (slot == SLOT_W'(INTERP-1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      slot <= '0;
      bitIdx <= '0;
    end else if (inValid) begin
      active <= 1'b1;
      slot <= '0;
      bitIdx <= '0;
    end else if (active) begin
      if (lastBit) begin
        bitIdx <= '0;
        slot <= slot + 1'b1;
        if (groupEnd) active <= 1'b0;
      end else begin
        bitIdx <= bitIdx + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.shiftIn = inValid;
    strobes.active = active;
    strobes.slot = slot;
    strobes.bitIdx = bitIdx;
    strobes.lastBit = lastBit;
  end

  // R8: a new input only when idle or on the final bit of the group
  assert_input_spacing_R8: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> (!active || groupEnd));

  // R2: an accepted input starts phase 0 at bit 0 on the next cycle
  assert_group_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (active && slot == '0 && bitIdx == '0));
endmodule

// File: rtl/rrc_da_path.sv
module rrc_da_path
  import rrc_da_pkg::*;
#(
  parameter int COEF_W = 12,
  parameter int OUT_W = 10,
  parameter logic [16*COEF_W-1:0] COEFS = '0
) (
  input  logic clk,
  input  logic rstN,
  input  ctrlStrobes_t strobes,
  input  logic [SAMPLE_W-1:0] inI,
  input  logic [SAMPLE_W-1:0] inQ,
  output logic outValid,
  output logic outQ,
  output logic [OUT_W-1:0] outData
);
  localparam int NTAP = INTERP * TAPS_PER_PHASE;
  localparam int HALF = NTAP / 2;
  localparam int LUT_IN = TAPS_PER_PHASE / 2;
  localparam int NSETS = INTERP / 2;
  localparam int SET_W = $clog2(NSETS);
  localparam int LUT_W = COEF_W + $clog2(LUT_IN);
  localparam int SUM_W = LUT_W + 1;
  localparam int YW = COEF_W + SAMPLE_W + $clog2(TAPS_PER_PHASE);
  localparam int ACC_W = SUM_W + SAMPLE_W + 1;

  function automatic logic signed [COEF_W-1:0] coefAt(int n);
    int idx;
    idx = (n < HALF) ? n : NTAP - 1 - n;
    return COEFS[idx*COEF_W +: COEF_W];
  endfunction

  function automatic logic signed [LUT_W-1:0] lutEntry(int setIdx, int half, int addr);
    logic signed [LUT_W-1:0] acc;
    logic signed [COEF_W-1:0] c;
    acc = '0;
    for (int b = 0; b < LUT_IN; b++) begin
      if (addr[b]) begin
        c = coefAt(INTERP * (half * LUT_IN + b) + setIdx);
        acc = acc + {{(LUT_W-COEF_W){c[COEF_W-1]}}, c};
      end
    end
    return acc;
  endfunction

  logic signed [LUT_W-1:0] lutRom [NSETS][2][1<<LUT_IN];
  for (genvar s = 0; s < NSETS; s++) begin : g_set
    for (genvar h = 0; h < 2; h++) begin : g_half
      for (genvar a = 0; a < (1<<LUT_IN); a++) begin : g_addr
        assign lutRom[s][h][a] = lutEntry(s, h, a);
      end
    end
  end

  logic [SAMPLE_W-1:0] histI [TAPS_PER_PHASE];
  logic [SAMPLE_W-1:0] histQ [TAPS_PER_PHASE];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < TAPS_PER_PHASE; k++) begin
        histI[k] <= '0;
        histQ[k] <= '0;
      end
    end else if (strobes.shiftIn) begin
      histI[0] <= inI;
      histQ[0] <= inQ;
      for (int k = 1; k < TAPS_PER_PHASE; k++) begin
        histI[k] <= histI[k-1];
        histQ[k] <= histQ[k-1];
      end
    end
  end

  logic isQ, rev;
  logic [SET_W-1:0] setSel;
  logic [SAMPLE_W-1:0] selHist [TAPS_PER_PHASE];
  logic [LUT_IN-1:0] addrLo, addrHi;

  always_comb begin
    int p;
    p = int'(strobes.slot);
    isQ = strobes.slot[0];
    rev = (p >= NSETS);
    setSel = rev ? SET_W'(INTERP - 1 - p) : SET_W'(p);
    for (int k = 0; k < TAPS_PER_PHASE; k++)
      selHist[k] = isQ ? histQ[k] : histI[k];
    for (int b = 0; b < LUT_IN; b++) begin
      addrLo[b] = selHist[rev ? TAPS_PER_PHASE - 1 - b : b][strobes.bitIdx];
      addrHi[b] = selHist[rev ? TAPS_PER_PHASE - 1 - (LUT_IN + b) : LUT_IN + b][strobes.bitIdx];
    end
  end

  logic signed [LUT_W-1:0] lutLo, lutHi;
  logic signed [SUM_W-1:0] lutSum, term;
  logic signed [ACC_W-1:0] acc, accBase, termExt, wide, accNext;
  logic neg;

  assign lutLo = lutRom[setSel][0][addrLo];
  assign lutHi = lutRom[setSel][1][addrHi];
  assign lutSum = {lutLo[LUT_W-1], lutLo} + {lutHi[LUT_W-1], lutHi};
  assign neg = strobes.lastBit;
  assign term = (lutSum ^ {SUM_W{neg}}) + {{(SUM_W-1){1'b0}}, neg};
  assign termExt = {{(ACC_W-SUM_W){term[SUM_W-1]}}, term};
  assign accBase = (strobes.bitIdx == '0) ? '0 : acc;
  assign wide = accBase + (termExt <<< SAMPLE_W);
  assign accNext = wide >>> 1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0;
      outValid <= 1'b0;
      outQ <= 1'b0;
      outData <= '0;
    end else begin
      outValid <= 1'b0;
      if (strobes.active) begin
        acc <= accNext;
        if (strobes.lastBit) begin
          outValid <= 1'b1;
          outQ <= isQ;
          outData <= accNext[YW-1 -: OUT_W];
        end
      end
    end
  end

  logic lastTag;
  always_ff @(posedge clk) begin
    if (!rstN) lastTag <= 1'b1;
    else if (outValid) lastTag <= outQ;
  end

  // R7: the exact result must fit the 18-bit range before truncation
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.lastBit |-> ($countones(accNext[ACC_W-1:YW-1]) == 0 ||
                         $countones(accNext[ACC_W-1:YW-1]) == ACC_W - YW + 1));

  // R9: each response is a single-cycle pulse
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R3: responses alternate between I and Q, starting with I
  assert_tag_alternates_R3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outQ != lastTag));
endmodule

// File: rtl/rrc_da_interp.sv
module rrc_da_interp
  import rrc_da_pkg::*;
#(
  parameter int COEF_W = 12,
  parameter int OUT_W = 10,
  parameter logic [16*COEF_W-1:0] COEFS = {
    12'sd1040, 12'sd820, 12'sd480, 12'sd160, -12'sd40, -12'sd132, -12'sd118, -12'sd50,
    12'sd18, 12'sd54, 12'sd52, 12'sd24, -12'sd6, -12'sd22, -12'sd20, -12'sd8}
) (
  input  logic clk,
  input  logic rstN,
  input  logic inValid,
  input  logic [SAMPLE_W-1:0] inI,
  input  logic [SAMPLE_W-1:0] inQ,
  output logic outValid,
  output logic outQ,
  output logic [OUT_W-1:0] outData
);
  ctrlStrobes_t strobes;

  rrc_da_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .strobes(strobes)
  );

  rrc_da_path #(.COEF_W(COEF_W), .OUT_W(OUT_W), .COEFS(COEFS)) u_path (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inI(inI), .inQ(inQ),
    .outValid(outValid), .outQ(outQ), .outData(outData)
  );
endmodule

// File: tb/sim_rrc_da_interp.sv
module sim_rrc_da_interp;
  localparam int CLK_PERIOD = 10;
  localparam int GAP = 12;
  localparam logic [16*12-1:0] TB_COEFS = {
    12'sd1040, 12'sd820, 12'sd480, 12'sd160, -12'sd40, -12'sd132, -12'sd118, -12'sd50,
    12'sd18, 12'sd54, 12'sd52, 12'sd24, -12'sd6, -12'sd22, -12'sd20, -12'sd8};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [2:0] inI = '0, inQ = '0;
  logic outValid, outQ;
  logic [9:0] outData;

  rrc_da_interp #(.COEFS(TB_COEFS)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inI(inI), .inQ(inQ),
    .outValid(outValid), .outQ(outQ), .outData(outData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  int mI [8], mQ [8];
  logic [9:0] expData [256];
  logic expTag [256];
  int expCyc [256];
  logic [7:0] head = 0, tail = 0;

  function automatic int coefM(int n);
    int idx;
    logic signed [11:0] c;
    idx = (n < 16) ? n : 31 - n;
    c = TB_COEFS[idx*12 +: 12];
    return int'(c);
  endfunction

  // Output monitor: compares each response with the model queue
  always @(negedge clk) begin
    if (rstN && outValid) begin
      checks++;
      if (head == tail) begin
        fails++;
        $display("FAIL R9 unexpected response: actual data=%0d expected none", outData);
      end else begin
        if (outData !== expData[head]) begin
          fails++;
          $display("FAIL R4/R7 data: actual=%0d expected=%0d", $signed(outData), $signed(expData[head]));
        end
        checks++;
        if (outQ !== expTag[head]) begin
          fails++;
          $display("FAIL R3 tag: actual=%0d expected=%0d", outQ, expTag[head]);
        end
        checks++;
        if (cyc != expCyc[head]) begin
          fails++;
          $display("FAIL R2 timing: actual cycle=%0d expected=%0d", cyc, expCyc[head]);
        end
        head = head + 1;
      end
    end
  end

  task automatic pushSample(int xi, int xq);
    int y;
    logic signed [17:0] yv;
    @(negedge clk);
    inI = 3'(xi);
    inQ = 3'(xq);
    inValid = 1'b1;
    for (int k = 7; k > 0; k--) begin
      mI[k] = mI[k-1];
      mQ[k] = mQ[k-1];
    end
    mI[0] = xi;
    mQ[0] = xq;
    for (int p = 0; p < 4; p++) begin
      y = 0;
      for (int k = 0; k < 8; k++)
        y += coefM(4*k + p) * ((p % 2 == 1) ? mQ[k] : mI[k]);
      yv = 18'(y);
      expData[tail] = yv[17:8];
      expTag[tail] = (p % 2 == 1);
      expCyc[tail] = cyc + 3*p + 4;
      tail = tail + 1;
    end
    @(negedge clk);
    inValid = 1'b0;
    repeat (GAP - 2) @(negedge clk);
  endtask

  task automatic drainCheck(string tag);
    repeat (GAP + 4) @(negedge clk);
    checks++;
    if (head != tail) begin
      fails++;
      $display("FAIL R9 %s: actual missing responses=%0d expected 0", tag, tail - head);
    end
  endtask

  task automatic testReset;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || outData !== '0) begin
      fails++;
      $display("FAIL R1 reset: actual valid=%0d data=%0d expected 0/0", outValid, outData);
    end
  endtask

  task automatic testImpulseI;  // R4, R5: Q responses stay zero
    pushSample(1, 0);
    for (int i = 0; i < 8; i++) pushSample(0, 0);
    drainCheck("impulse I");
  endtask

  task automatic testNegImpulseQ;  // R6, R5: full-scale negative on Q only
    pushSample(0, -4);
    for (int i = 0; i < 8; i++) pushSample(0, 0);
    drainCheck("impulse Q");
  endtask

  task automatic testAlternating;  // R6: extremes of both signs
    for (int i = 0; i < 10; i++) pushSample((i % 2) ? 3 : -4, (i % 2) ? -4 : 3);
    drainCheck("alternating");
  endtask

  task automatic testFullScale;  // R7: largest magnitude results
    for (int i = 0; i < 10; i++) pushSample(-4, -4);
    for (int i = 0; i < 10; i++) pushSample(3, 3);
    drainCheck("full scale");
  endtask

  task automatic testRandom;  // R4, R8: back-to-back inputs at minimum spacing
    logic [7:0] lfsr = 8'hA5;
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      pushSample(int'($signed(lfsr[2:0])), int'($signed(lfsr[6:4])));
    end
    drainCheck("random");
  endtask

  bit done = 0;
  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) begin
      mI[k] = 0;
      mQ[k] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    repeat (4) @(negedge clk);
    testReset();
    testImpulseI();
    testNegImpulseQ();
    testAlternating();
    testFullScale();
    testRandom();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule